// File: doc/BRIEF.md
# Dual-Stream Rate Multiplier DAC

This block turns a parallel digital code into two one-bit pulse streams. Off-chip, a resistor pair with a 64:1 ratio sums the streams, and a low-pass filter smooths the result into an analog level. The code is split into two halves. The upper half sets the pulse density of a coarse stream. The lower half sets the pulse density of a fine stream. One free-running binary counter serves both streams, so a full conversion cycle lasts 2^SEG_W clocks instead of 2^(2·SEG_W).

The counter's state is decoded into SEG_W mutually exclusive, binary-weighted enables called pickets. The heaviest picket fires on every other clock. Each lighter picket fires half as often as the one above it. Each stream ANDs every picket with its own weight bit, ORs the products, and registers the result. The result is a glitch-free output whose high count per cycle equals the value of its code half. The input code is captured only at the counter's wrap, so a code change never lands in the middle of a cycle. A one-clock strobe marks the first clock of each cycle.

Top module: `rmdac_dual`

## Requirements
- R1: The phase counter advances by one on every clock after reset and wraps from 2^SEG_W-1 to 0. `cycle_start` is high exactly when the counter is 0, which is once every 2^SEG_W clocks.
- R2: The heaviest picket is active whenever counter bit 0 is 0. With only the top code bit (bit 11 at default) set, `dac_coarse` is high on window positions 0, 2, 4, … and low on odd positions.
- R3: The picket for counter bit k (k ≥ 1) is active when counter bit k is 0 and all lower counter bits are 1. The lightest picket (k = SEG_W-1) fires once per window, at position 2^(SEG_W-1)-1 (31 at default). It is weighted by code bit SEG_W (coarse) and code bit 0 (fine).
- R4: At most one picket is active on any clock. With an all-ones code, each stream is high on every window position except the last (2^SEG_W-1).
- R5: Over each aligned window, the number of high cycles on `dac_coarse` equals code bits [2·SEG_W-1:SEG_W]. The number on `dac_fine` equals code bits [SEG_W-1:0].
- R6: Both outputs are registered. The output value in the clock after the counter holds value p is set by the picket active at p.
- R7: The code is loaded into the holding register only on the clock where the counter wraps to 0. A code change partway through a window does not change that window's output and takes effect from the next window.
- R8: Synchronous reset clears the counter, the holding register and both outputs. The first window after reset therefore outputs no pulses, whatever the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 2*SEG_W | Parallel code; upper half coarse, lower half fine |
| dac_coarse | output | 1 | Registered coarse pulse stream |
| dac_fine | output | 1 | Registered fine pulse stream |
| cycle_start | output | 1 | High on the first clock of each conversion window |

## Verification
The bench builds the block at the default SEG_W = 6. This gives a 64-clock window and a 4096-value code space. Short windows let a cycle-exact reference model follow every output bit through about fifty windows. The window is also long enough that the lightest picket's single position (31) and the heaviest picket's alternation can be told apart. Random codes cover the density sums. Directed codes (zero, full scale, single top bit, single bottom bits, a change partway through a window) reach the window edges and the load timing.

// File: rtl/rmdac_pkg.sv
package rmdac_pkg;
   // Index of each output stream inside the stream generate loop
   typedef enum int {
      STREAM_FINE   = 0,
      STREAM_COARSE = 1
   } rmdac_stream_e;

   localparam int RMDAC_NUM_STREAMS = 2;
   localparam int RMDAC_MIN_SEG_W   = 2;
   localparam int RMDAC_MAX_SEG_W   = 16;
endpackage

// File: rtl/rmdac_phase_ctr.sv
// Free-running binary phase counter with wrap and start decodes.
module rmdac_phase_ctr #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] phase,
   output logic         last,
   output logic         first
);
   always_ff @(posedge clk) begin
      if (rst) phase <= '0;
      else     phase <= phase + 1'b1;
   end

   assign last  = &phase;
   assign first = ~|phase;
endmodule

// File: rtl/rmdac_picket_dec.sv
// Decodes the phase into mutually exclusive binary-weighted enables.
// Enable k fires when phase bit k is low and every bit below it is high.
module rmdac_picket_dec #(
   parameter int W = 6
) (
   input  logic [W-1:0] phase,
   output logic [W-1:0] picket
);
   for (genvar k = 0; k < W; k++) begin : g_pk
      if (k == 0) begin : g_heavy
         assign picket[k] = ~phase[0];
      end else begin : g_light
         assign picket[k] = ~phase[k] & (&phase[k-1:0]);
      end
   end
endmodule

// File: rtl/rmdac_stream.sv
// One weighted stream: the heaviest enable pairs with the top weight bit.
module rmdac_stream #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] picket,
   input  logic [W-1:0] weight,
   output logic         dout
);
   logic [W-1:0] hit;

   for (genvar k = 0; k < W; k++) begin : g_hit
      assign hit[k] = picket[k] & weight[W-1-k];
   end

   always_ff @(posedge clk) begin
      if (rst) dout <= 1'b0;
      else     dout <= |hit;
   end
endmodule

// File: rtl/rmdac_dual.sv
module rmdac_dual
   import rmdac_pkg::*;
#(
   parameter int SEG_W = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [2*SEG_W-1:0] code,
   output logic               dac_coarse,
   output logic               dac_fine,
   output logic               cycle_start
);
   localparam int CODE_W = RMDAC_NUM_STREAMS * SEG_W;

   if (SEG_W < RMDAC_MIN_SEG_W || SEG_W > RMDAC_MAX_SEG_W) begin : g_bad_seg_w
      $error("rmdac_dual: SEG_W out of supported range");
   end

   logic [SEG_W-1:0]             phase;
   logic [SEG_W-1:0]             picket;
   logic                         phase_last;
   logic                         phase_first;
   logic [CODE_W-1:0]            held;
   logic [RMDAC_NUM_STREAMS-1:0] stream_out;

   rmdac_phase_ctr #(.W(SEG_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .phase (phase),
      .last  (phase_last),
      .first (phase_first)
   );

   // Code is taken only at the wrap so a window is never split
   always_ff @(posedge clk) begin
      if (rst)             held <= '0;
      else if (phase_last) held <= code;
   end

   rmdac_picket_dec #(.W(SEG_W)) u_dec (
      .phase  (phase),
      .picket (picket)
   );

   for (genvar s = 0; s < RMDAC_NUM_STREAMS; s++) begin : g_stream
      rmdac_stream #(.W(SEG_W)) u_str (
         .clk    (clk),
         .rst    (rst),
         .picket (picket),
         .weight (held[s*SEG_W +: SEG_W]),
         .dout   (stream_out[s])
      );
   end

   assign dac_fine    = stream_out[STREAM_FINE];
   assign dac_coarse  = stream_out[STREAM_COARSE];
   assign cycle_start = phase_first;
endmodule

// File: rtl/rmdac_dual_chk.sv
module rmdac_dual_chk #(
   parameter int SEG_W = 6
) (
   input logic               clk,
   input logic               rst,
   input logic [SEG_W-1:0]   phase,
   input logic [SEG_W-1:0]   picket,
   input logic [2*SEG_W-1:0] held,
   input logic               dac_coarse,
   input logic               dac_fine,
   input logic               cycle_start
);
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phase == SEG_W'($past(phase) + 1'b1)); // R1
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
      cycle_start |=> !cycle_start); // R1
   AST_HEAVY_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
      picket[0] |=> !picket[0]); // R2
   AST_PICKET_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(picket)); // R4
   AST_COARSE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (held[2*SEG_W-1:SEG_W] == '0) |=> !dac_coarse); // R5
   AST_FINE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (held[SEG_W-1:0] == '0) |=> !dac_fine); // R5
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
      !(&phase) |=> $stable(held)); // R7
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!dac_coarse && !dac_fine && cycle_start)); // R8
endmodule

bind rmdac_dual rmdac_dual_chk #(.SEG_W(SEG_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .phase       (phase),
   .picket      (picket),
   .held        (held),
   .dac_coarse  (dac_coarse),
   .dac_fine    (dac_fine),
   .cycle_start (cycle_start)
);

// File: tb/rmdac_dual_bench.sv
module rmdac_dual_bench;
   localparam int SEG_W  = 6;
   localparam int CODE_W = 2 * SEG_W;
   localparam int WIN    = 1 << SEG_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [CODE_W-1:0] code = '0;
   logic              dac_coarse, dac_fine, cycle_start;

   always #10 clk = ~clk; // 50 MHz

   rmdac_dual #(.SEG_W(SEG_W)) u_rmdac_dual (
      .clk(clk), .rst(rst), .code(code),
      .dac_coarse(dac_coarse), .dac_fine(dac_fine), .cycle_start(cycle_start)
   );

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   bit chk_en = 1'b0;
   bit ended  = 1'b0;

   task automatic check(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected stream bit at window position p, from the picket rules
   function automatic logic pick_bit(int p, logic [SEG_W-1:0] seg);
      int k = 0;
      while (k < SEG_W && p[k]) k++;
      return (k < SEG_W) ? seg[SEG_W-1-k] : 1'b0;
   endfunction

   // Cycle-level reference: position, captured code, expected outputs
   int                mp = 0;
   logic [CODE_W-1:0] mh = '0;
   logic              ec = 1'b0, ef = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         mp = 0; mh = '0; ec = 1'b0; ef = 1'b0;
      end else begin
         ec = pick_bit(mp, mh[CODE_W-1:SEG_W]);
         ef = pick_bit(mp, mh[SEG_W-1:0]);
         if (mp == WIN - 1) mh = code;
         mp = (mp + 1) % WIN;
      end
   end

   always @(negedge clk) begin
      if (!rst && chk_en && !ended) begin
         check(dac_coarse == ec, "R6 coarse per-cycle", dac_coarse, ec);
         check(dac_fine == ef, "R6 fine per-cycle", dac_fine, ef);
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !ended) begin
         ended = 1'b1;
         fails++;
         tests++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   logic c_bits [WIN];
   logic f_bits [WIN];
   int   sc, sf;

   // Called at a negedge where cycle_start is high; ends at the next one
   task automatic measure();
      sc = 0; sf = 0;
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         c_bits[i] = dac_coarse;
         f_bits[i] = dac_fine;
         sc += int'(dac_coarse);
         sf += int'(dac_fine);
         check(cycle_start == (i == WIN - 1), "R1 start strobe spacing",
               cycle_start, (i == WIN - 1));
      end
   endtask

   task automatic apply(logic [CODE_W-1:0] c);
      code = c;
      @(negedge clk);
      while (!cycle_start) @(negedge clk);
   endtask

   task automatic run_code(logic [CODE_W-1:0] c);
      apply(c);
      measure();
      check(sc == int'(c[CODE_W-1:SEG_W]), "R5 coarse density", sc, int'(c[CODE_W-1:SEG_W]));
      check(sf == int'(c[SEG_W-1:0]), "R5 fine density", sf, int'(c[SEG_W-1:0]));
   endtask

   initial begin
      void'($urandom(32'h5EED_0A17));
      // R8: reset state, with a non-zero code present
      rst  = 1'b1;
      code = '1;
      repeat (4) @(negedge clk);
      check(dac_coarse == 1'b0, "R8 coarse in reset", dac_coarse, 0);
      check(dac_fine == 1'b0, "R8 fine in reset", dac_fine, 0);
      check(cycle_start == 1'b1, "R8 counter cleared", cycle_start, 1);
      rst    = 1'b0;
      chk_en = 1'b1;
      // First window after reset uses the cleared holding register
      measure();
      check(sc == 0, "R8 first window coarse", sc, 0);
      check(sf == 0, "R8 first window fine", sf, 0);
      // R4: full scale, low only at last position
      measure();
      check(sc == WIN - 1, "R4 full-scale coarse", sc, WIN - 1);
      check(sf == WIN - 1, "R4 full-scale fine", sf, WIN - 1);
      check(c_bits[WIN-1] == 1'b0, "R4 last position empty", c_bits[WIN-1], 0);
      check(f_bits[WIN-1] == 1'b0, "R4 last position empty fine", f_bits[WIN-1], 0);

      // R2: heaviest picket only
      run_code(12'h800);
      for (int i = 0; i < WIN; i++)
         check(c_bits[i] == ((i % 2) == 0), "R2 alternate clocks", c_bits[i], ((i % 2) == 0));

      // R3: lightest picket on both streams
      run_code(12'h041);
      for (int i = 0; i < WIN; i++) begin
         check(c_bits[i] == (i == 31), "R3 lightest coarse position", c_bits[i], (i == 31));
         check(f_bits[i] == (i == 31), "R3 lightest fine position", f_bits[i], (i == 31));
      end

      // R3: middle picket (k=2 -> weight 8), fine only
      run_code(12'h008);
      for (int i = 0; i < WIN; i++)
         check(f_bits[i] == ((i % 8) == 3), "R3 middle picket fine", f_bits[i], ((i % 8) == 3));

      run_code(12'h000);

      // R7: code change partway through a window is ignored until the wrap
      apply(12'hA5C);
      sc = 0; sf = 0;
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         if (i == 20) code = 12'h3F0;
         sc += int'(dac_coarse);
         sf += int'(dac_fine);
      end
      check(sc == 12'hA5C >> SEG_W, "R7 mid-window change coarse", sc, 12'hA5C >> SEG_W);
      check(sf == (12'hA5C & 12'h03F), "R7 mid-window change fine", sf, 12'hA5C & 12'h03F);
      measure();
      check(sc == 6'h0F, "R7 new code next window coarse", sc, 6'h0F);
      check(sf == 6'h30, "R7 new code next window fine", sf, 6'h30);

      // R5: random codes
      for (int n = 0; n < 40; n++) run_code(CODE_W'($urandom));

      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule